// File: doc/BRIEF.md
# UART receive interrupt identification unit

This unit gathers the receive-side interrupt causes of a UART that runs either as a single-character holding register or in FIFO mode. It latches line errors, compares the receive FIFO fill level against a programmable threshold, and runs a character-time idle counter. The highest-priority pending cause is reported as a read-only interrupt status byte, together with an active-high interrupt request.

The surrounding UART supplies the current receive occupancy, a one-cycle strobe for each character pushed into the receive store, and strobes for reads of the receive data register and the line status register. It also supplies a tick once per character time, the FIFO-mode control bit, a one-cycle receive FIFO reset strobe, and per-source enables. Character framing, baud timing, transmit and modem causes, and the FIFO storage itself live elsewhere.

Top module: `rx_irq_ident`

## Requirements
- R1: After reset with `fifo_en`=0 and no source active, `isr` reads 0x01 and `irq` is 0.
- R2: `isr[7]` and `isr[6]` both equal `fifo_en`, and `isr[5:4]` is always 00.
- R3: A one-cycle pulse on any of the four error inputs makes the line-status cause pending from the next cycle, shown as `isr[3:1]`=011. It stays pending, even after the error input drops, until a cycle with `lsr_rd`=1. It is clear from the cycle after that read, unless a new error arrives in the same cycle as the read.
- R4: With `fifo_en`=0 the data cause (`isr[3:1]`=010) is pending exactly while `rx_count` is non-zero, so a read that empties the holding register clears it.
- R5: With `fifo_en`=1 and `rx_trig` between 1 and the FIFO depth, the data cause is pending exactly while `rx_count` >= `rx_trig` (combinational from the inputs). Reads that bring `rx_count` below `rx_trig` clear it.
- R6: With `fifo_en`=1 and `rx_count` non-zero, four `char_tick` pulses with no `rbr_rd` and no `rx_push` make the timeout cause (`isr[3:1]`=110) pending from the cycle after the fourth tick. It is clear from the cycle after an `rbr_rd`.
- R7: The idle count restarts on every `rbr_rd` and every `rx_push`, and ticks that occur while `rx_count` is 0 are not counted.
- R8: With `fifo_en`=0, `isr[3]` is 0 and no timeout can build up, so switching to FIFO mode never shows a timeout left over from non-FIFO mode.
- R9: While `fifo_clr` is 1, the data and timeout causes are masked. A timeout pending before the strobe is still clear after it.
- R10: Priority is line status over data available over timeout. `isr[0]` is 1 only when none of the three is pending.
- R11: `ls_ien` gates the line-status cause, and `rda_ien` gates both the data and the timeout causes. A gated cause affects neither `isr` nor `irq`, and `irq` is always the inverse of `isr[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode control bit |
| fifo_clr | input | 1 | One-cycle receive FIFO reset strobe |
| rx_trig | input | CNT_W | Receive threshold in characters |
| rx_count | input | CNT_W | Current receive occupancy |
| rx_push | input | 1 | A character was written into the receive store |
| rbr_rd | input | 1 | Receive data register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| err_ovr | input | 1 | Overrun error |
| err_par | input | 1 | Parity error |
| err_frm | input | 1 | Missing stop bit |
| err_brk | input | 1 | Break detected |
| char_tick | input | 1 | One pulse per character time |
| ls_ien | input | 1 | Line-status cause enable |
| rda_ien | input | 1 | Data and timeout cause enable |
| isr | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following: the fixed upper bits, that bit 3 stays clear in non-FIFO mode, that a pending line-status cause always owns the code field, and that latched errors persist until the status read. They also check that the idle counter never passes its limit and restarts on each access. Only the bench scenarios can show that the threshold comparison is right across every pairing of level and occupancy. The same holds for the exact tick on which the timeout appears, the ordering when all three causes coexist, and the masking by each enable.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

  localparam logic [2:0] CODE_NONE = 3'b000;
  localparam logic [2:0] CODE_LS   = 3'b011;
  localparam logic [2:0] CODE_RDA  = 3'b010;
  localparam logic [2:0] CODE_TMO  = 3'b110;

  // Data-available condition for a given mode, occupancy and threshold.
  function automatic logic data_ready(input logic fen, input logic [7:0] cnt,
                                      input logic [7:0] trig);
    if (fen) return (cnt != 8'd0) && (cnt >= trig);
    else     return (cnt != 8'd0);
  endfunction

  // Assemble the status byte from mode, cause code and pending flag.
  function automatic logic [7:0] pack_status(input logic fen, input logic [2:0] code,
                                             input logic pend);
    return {fen, fen, 2'b00, code, ~pend};
  endfunction

endpackage

// File: rtl/rx_err_latch.sv
module rx_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic err_ovr,
  input  logic err_par,
  input  logic err_frm,
  input  logic err_brk,
  input  logic lsr_rd,
  output logic err_held
);

  logic any_err;
  assign any_err = err_ovr | err_par | err_frm | err_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_held <= 1'b0;
    else if (any_err) err_held <= 1'b1;
    else if (lsr_rd)  err_held <= 1'b0;
  end

  // R3
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_held && !lsr_rd) |=> err_held);

  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> err_held);

endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout #(
  parameter int TMO_CHARS = 4,
  parameter int TMO_W     = $clog2(TMO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_en,
  input  logic fifo_clr,
  input  logic fifo_nonempty,
  input  logic rbr_rd,
  input  logic rx_push,
  input  logic char_tick,
  output logic tmo_flag
);

  localparam logic [TMO_W-1:0] LIMIT = TMO_W'(TMO_CHARS);

  logic [TMO_W-1:0] idle_cnt;
  logic [TMO_W-1:0] idle_nxt;
  logic             restart;

  assign restart  = !fifo_en || fifo_clr || !fifo_nonempty || rbr_rd || rx_push;
  assign idle_nxt = idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      tmo_flag <= 1'b0;
    end else if (restart) begin
      idle_cnt <= '0;
      tmo_flag <= 1'b0;
    end else if (char_tick && !tmo_flag) begin
      idle_cnt <= idle_nxt;
      if (idle_nxt == LIMIT) tmo_flag <= 1'b1;
    end
  end

  // R6
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= LIMIT);

  // R7
  tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd || rx_push) |=> (idle_cnt == '0 && !tmo_flag));

  // R8
  tmo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !tmo_flag);

endmodule

// File: rtl/rx_isr_encode.sv
module rx_isr_encode
  import rx_irq_pkg::*;
(
  input  logic       fifo_en,
  input  logic       ls_pend,
  input  logic       rda_pend,
  input  logic       tmo_pend,
  output logic [7:0] isr,
  output logic       irq
);

  logic [2:0] code;
  logic       any_pend;

  always_comb begin
    if (ls_pend)       code = CODE_LS;
    else if (rda_pend) code = CODE_RDA;
    else if (tmo_pend) code = CODE_TMO;
    else               code = CODE_NONE;
  end

  assign any_pend = ls_pend | rda_pend | tmo_pend;
  assign isr      = pack_status(fifo_en, code, any_pend);
  assign irq      = ~isr[0];

endmodule

// File: rtl/rx_irq_ident.sv
module rx_irq_ident
  import rx_irq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int TMO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             fifo_clr,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rbr_rd,
  input  logic             lsr_rd,
  input  logic             err_ovr,
  input  logic             err_par,
  input  logic             err_frm,
  input  logic             err_brk,
  input  logic             char_tick,
  input  logic             ls_ien,
  input  logic             rda_ien,
  output logic [7:0]       isr,
  output logic             irq
);

  localparam int TMO_W = $clog2(TMO_CHARS + 1);

  logic err_held;
  logic tmo_flag;
  logic data_cond;
  logic ls_pend;
  logic rda_pend;
  logic tmo_pend;

  rx_err_latch u_err (
    .clk(clk), .rst_n(rst_n),
    .err_ovr(err_ovr), .err_par(err_par), .err_frm(err_frm), .err_brk(err_brk),
    .lsr_rd(lsr_rd), .err_held(err_held)
  );

  rx_char_timeout #(.TMO_CHARS(TMO_CHARS), .TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
    .fifo_nonempty(rx_count != '0), .rbr_rd(rbr_rd), .rx_push(rx_push),
    .char_tick(char_tick), .tmo_flag(tmo_flag)
  );

  assign data_cond = data_ready(fifo_en, 8'(rx_count), 8'(rx_trig));
  assign ls_pend   = err_held & ls_ien;
  assign rda_pend  = data_cond & rda_ien & ~fifo_clr;
  assign tmo_pend  = tmo_flag & rda_ien & fifo_en & ~fifo_clr;

  rx_isr_encode u_enc (
    .fifo_en(fifo_en), .ls_pend(ls_pend), .rda_pend(rda_pend), .tmo_pend(tmo_pend),
    .isr(isr), .irq(irq)
  );

  // R2
  upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[7] == fifo_en) && (isr[6] == fifo_en) && (isr[5:4] == 2'b00));

  // R8
  bit3_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !isr[3]);

  // R10
  ls_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_pend |-> (isr[3:1] == CODE_LS));

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_held && !data_cond && !tmo_flag) |-> (isr[0] && !irq));

endmodule

// File: tb/rx_irq_ident_tb.sv
`timescale 1ns/1ps
module rx_irq_ident_tb;

  localparam int CNT_W = 5;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, fifo_clr = 0, rx_push = 0, rbr_rd = 0, lsr_rd = 0;
  logic err_ovr = 0, err_par = 0, err_frm = 0, err_brk = 0, char_tick = 0;
  logic ls_ien = 1, rda_ien = 1;
  logic [CNT_W-1:0] rx_trig = 5'd1, rx_count = '0;
  logic [7:0] isr;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_irq_ident #(.CNT_W(CNT_W), .TMO_CHARS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
    .rx_trig(rx_trig), .rx_count(rx_count), .rx_push(rx_push), .rbr_rd(rbr_rd),
    .lsr_rd(lsr_rd), .err_ovr(err_ovr), .err_par(err_par), .err_frm(err_frm),
    .err_brk(err_brk), .char_tick(char_tick), .ls_ien(ls_ien), .rda_ien(rda_ien),
    .isr(isr), .irq(irq)
  );

  // Expected byte: mode bits on top, code of highest pending cause below.
  function automatic logic [7:0] expect_isr(input logic fen, input logic ls,
                                            input logic rda, input logic tmo);
    logic [7:0] v;
    v = fen ? 8'hC0 : 8'h00;
    if (ls)       v = v + 8'h06;
    else if (rda) v = v + 8'h04;
    else if (tmo) v = v + 8'h0C;
    else          v = v + 8'h01;
    return v;
  endfunction

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (isr !== exp || irq !== ~exp[0]) begin
      n_bad++;
      $display("FAIL %s: isr=%h irq=%b expected isr=%h irq=%b", req, isr, irq, exp, ~exp[0]);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic tick(); char_tick = 1; cyc(); char_tick = 0; endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) tick(); endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    chk("R1 reset", 8'h01);

    // R3: each error source latches, holds, clears on status read
    for (int e = 0; e < 4; e++) begin
      {err_ovr, err_par, err_frm, err_brk} = 4'b1000 >> e;
      cyc(); {err_ovr, err_par, err_frm, err_brk} = 4'b0;
      chk("R3 set", 8'h06);
      cyc(); cyc();
      chk("R3 hold", 8'h06);
      lsr_rd = 1; cyc(); lsr_rd = 0;
      chk("R3 clear", 8'h01);
    end
    err_par = 1; lsr_rd = 1; cyc(); err_par = 0; lsr_rd = 0;
    chk("R3 error with read", 8'h06);
    lsr_rd = 1; cyc(); lsr_rd = 0;

    // R4: non-FIFO holding register
    rx_count = 1; #1; chk("R4 data", 8'h04);
    ticks(6);
    chk("R4 R8 no timeout non-fifo", 8'h04);
    rx_count = 0; #1; chk("R4 read empties", 8'h01);
    rx_count = 1; fifo_en = 1; rx_trig = 8; #1;
    chk("R8 no carried timeout", 8'hC1);
    rx_count = 0; cyc();

    // R5: sweep thresholds and occupancy
    for (int t = 1; t <= DEPTH; t++)
      for (int c = 0; c <= DEPTH; c++) begin
        rx_trig = CNT_W'(t); rx_count = CNT_W'(c); #1;
        chk("R5 threshold", expect_isr(1, 0, c >= t, 0));
      end
    rx_count = 0; fifo_en = 0; #1;
    chk("R2 mode bits off", 8'h01);
    fifo_en = 1; rx_trig = 8; cyc();

    // R6/R7: timeout, ticks while empty ignored
    ticks(5);
    rx_count = 1; cyc();
    ticks(3); chk("R7 empty ticks ignored", 8'hC1);
    tick(); chk("R6 timeout", 8'hCC);
    rbr_rd = 1; cyc(); rbr_rd = 0;
    chk("R6 read clears", 8'hC1);
    ticks(3); rx_push = 1; cyc(); rx_push = 0;
    ticks(3); chk("R7 push restarts", 8'hC1);
    tick(); chk("R7 timeout after restart", 8'hCC);
    rbr_rd = 1; cyc(); rbr_rd = 0;
    ticks(2); rbr_rd = 1; cyc(); rbr_rd = 0;
    ticks(3); chk("R7 read restarts", 8'hC1);
    tick(); chk("R6 fourth tick", 8'hCC);

    // R10: priority with all causes present
    rx_count = 2; rx_trig = 4; #1; chk("R6 held", 8'hCC);
    rx_trig = 2; #1; chk("R10 data over timeout", 8'hC4);
    err_frm = 1; cyc(); err_frm = 0;
    chk("R10 status over all", 8'hC6);

    // R11: enable sweep with all three pending
    for (int m = 0; m < 4; m++) begin
      {ls_ien, rda_ien} = 2'(m); #1;
      chk("R11 enables", expect_isr(1, m[1], m[0], m[0]));
    end
    ls_ien = 1; rda_ien = 1;
    lsr_rd = 1; cyc(); lsr_rd = 0;
    chk("R10 status read leaves data", 8'hC4);
    rx_trig = 4; #1; chk("R10 timeout last", 8'hCC);

    // R9: FIFO reset strobe
    rx_trig = 2; fifo_clr = 1; #1; chk("R9 masked during clear", 8'hC1);
    cyc(); fifo_clr = 0; rx_trig = 4; #1;
    chk("R9 timeout gone", 8'hC1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule